// File: doc/BRIEF.md
# Scatter-Gather Chain Walker

This block follows the list of buffer descriptors that belongs to one storage command and turns each descriptor into a single transfer request for the data mover downstream. A controller gives it the byte address of a descriptor table, the total length of the transfer and the direction, then pulses start. The walker reads each 16-byte descriptor as four 32-bit words over a simple request/valid fetch port. After it has the whole descriptor, it either issues a transfer, skips the entry, or jumps to another table.

The walk stops with a done pulse once the requested length has been covered. It stops with an error pulse and a held error code in three cases: the chain ends while bytes are still owed (one code for each direction), the starting table is not on an 8-byte boundary, or a link target is not on an 8-byte boundary. A descriptor can also mark its buffer as a sink: the data is dropped and the buffer address is not passed on.

Top module: `sg_chain_walker`

## Requirements
- R1: After reset, `fetch_req_o`, `xfer_valid_o`, `done_o` and `err_o` are low and `err_code_o` is 0. An asynchronous reset during a walk brings them back to these values.
- R2: A descriptor is read as four 32-bit words from four consecutive word addresses, beginning at the table address. The words are buffer address bits 31:0, buffer address bits 63:32, byte count, and flags. In the flags word, bit 31 means last entry, bit 30 means link and bit 29 means discard. A word is taken in each cycle in which `fetch_req_o` and `fetch_valid_i` are both high.
- R3: A data entry with a nonzero count produces a one-cycle `xfer_valid_o`. It carries the entry's address and a count equal to the smaller of the entry count and the bytes still owed.
- R4: When the bytes owed reach zero, `done_o` pulses for one cycle and no further descriptor word is fetched.
- R5: An entry whose count is zero produces no transfer. The walk moves on, or it ends if that entry is marked last.
- R6: For a link entry, its address becomes the next table address. The count, last and discard bits of a link entry have no effect.
- R7: A transfer from a discard entry has `xfer_discard_o` high and `xfer_addr_o` equal to 0.
- R8: If an entry marked last has been processed and bytes are still owed, `err_o` pulses. The code is 7 when `dev_write_i` was 1 at start and 8 when it was 0.
- R9: A start table address or link target whose low three bits are not all zero gives `err_o` with code 16. No word is fetched from that address.
- R10: A start with an aligned table and zero length gives `done_o` with no fetch and no transfer.
- R11: `err_code_o` keeps its value until the next start, and that start clears it to 0.
- R12: `done_o` and `err_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a walk (sampled while idle) |
| tbl_addr_i | input | ADDR_W | Byte address of the first descriptor table |
| xfer_len_i | input | LEN_W | Total bytes to cover |
| dev_write_i | input | 1 | 1: device supplies the data; 0: device receives it |
| fetch_req_o | output | 1 | Descriptor word request |
| fetch_addr_o | output | ADDR_W | Byte address of the requested word |
| fetch_valid_i | input | 1 | Requested word present on fetch_data_i |
| fetch_data_i | input | 32 | Descriptor word |
| xfer_valid_o | output | 1 | One-cycle transfer request |
| xfer_addr_o | output | ADDR_W | Buffer address (0 for discard) |
| xfer_cnt_o | output | LEN_W | Bytes to move |
| xfer_discard_o | output | 1 | Drop the data of this transfer |
| done_o | output | 1 | One-cycle walk-complete pulse |
| err_o | output | 1 | One-cycle walk-failed pulse |
| err_code_o | output | 6 | Failure code, held until next start |

## Verification
The walker is run over a fixed descriptor memory that holds several chains, with and without fetch stalls. A plain two-entry chain is walked with lengths that exactly match it, fall short of it, cut the second entry, or overrun it in each direction. Together these separate clipping, the early stop and the two direction codes. A second chain mixes a zero-count entry, a discard entry and a link whose count and last bit must be ignored. Misaligned starts and misaligned link targets, zero lengths and a chain whose only entry is empty and marked last cover the remaining outcomes. The number of fetch beats is compared in each case, to show that fetching stops where it should.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int FLAG_LAST_BIT = 31;
  localparam int FLAG_LINK_BIT = 30;
  localparam int FLAG_SINK_BIT = 29;
  localparam int CODE_W        = 6;
  localparam logic [CODE_W-1:0] CODE_SHORT_WR = 6'd7;
  localparam logic [CODE_W-1:0] CODE_SHORT_RD = 6'd8;
  localparam logic [CODE_W-1:0] CODE_ALIGN    = 6'd16;
  typedef enum logic [1:0] {W_IDLE, W_FETCH, W_ACT} walk_state_e;
endpackage

// File: rtl/sgw_gather.sv
module sgw_gather #(
  parameter int ADDR_W    = 64,
  parameter int WORD_W    = 32,
  parameter int ENT_WORDS = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        load_i,
  input  logic [ADDR_W-1:0]           load_addr_i,
  input  logic                        run_i,
  input  logic                        beat_valid_i,
  input  logic [WORD_W-1:0]           beat_data_i,
  output logic [ADDR_W-1:0]           fetch_addr_o,
  output logic                        last_beat_o,
  output logic [ENT_WORDS*WORD_W-1:0] words_o
);
  localparam int IDX_W = $clog2(ENT_WORDS);
  localparam int STEP  = WORD_W / 8;

  logic [ADDR_W-1:0] ptr_q, ptr_n;
  logic [IDX_W-1:0]  idx_q, idx_n;
  logic              take;

  assign take = run_i & beat_valid_i;

  always_comb begin
    ptr_n = ptr_q;
    idx_n = idx_q;
    if (load_i) begin
      ptr_n = load_addr_i;
      idx_n = '0;
    end else if (take) begin
      ptr_n = ptr_q + ADDR_W'(STEP);
      idx_n = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      idx_q <= '0;
    end else begin
      ptr_q <= ptr_n;
      idx_q <= idx_n;
    end
  end

  for (genvar g = 0; g < ENT_WORDS; g++) begin : g_word
    logic [WORD_W-1:0] w_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          w_q <= '0;
      else if (take && idx_q == IDX_W'(g)) w_q <= beat_data_i;
    end
    assign words_o[g*WORD_W +: WORD_W] = w_q;
  end

  assign fetch_addr_o = ptr_q;
  assign last_beat_o  = take && (idx_q == IDX_W'(ENT_WORDS - 1));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !load_i) |=> fetch_addr_o == $past(fetch_addr_o) + ADDR_W'(STEP));
endmodule

// File: rtl/sgw_len.sv
module sgw_len #(
  parameter int LEN_W = 32,
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] load_len_i,
  input  logic             use_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [LEN_W-1:0] clip_o,
  output logic             exhaust_o
);
  logic [LEN_W-1:0] rem_q, rem_n, cnt_ext;

  assign cnt_ext   = LEN_W'(cnt_i);
  assign exhaust_o = cnt_ext >= rem_q;
  assign clip_o    = exhaust_o ? rem_q : cnt_ext;

  always_comb begin
    rem_n = rem_q;
    if (load_i)     rem_n = load_len_i;
    else if (use_i) rem_n = rem_q - clip_o;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rem_q <= '0;
    else        rem_q <= rem_n;
  end

  // R3
  rem_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> rem_q <= $past(rem_q));
endmodule

// File: rtl/sg_chain_walker.sv
module sg_chain_walker
  import sgw_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] tbl_addr_i,
  input  logic [LEN_W-1:0]  xfer_len_i,
  input  logic              dev_write_i,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  input  logic              fetch_valid_i,
  input  logic [31:0]       fetch_data_i,
  output logic              xfer_valid_o,
  output logic [ADDR_W-1:0] xfer_addr_o,
  output logic [LEN_W-1:0]  xfer_cnt_o,
  output logic              xfer_discard_o,
  output logic              done_o,
  output logic              err_o,
  output logic [5:0]        err_code_o
);
  localparam int WORD_W     = 32;
  localparam int ENT_WORDS  = 4;
  localparam int ALIGN_BITS = 3;

  walk_state_e       state_q, state_n;
  logic              wr_q, wr_n, done_q, done_n, err_q, err_n;
  logic [CODE_W-1:0] code_q, code_n;
  logic              xv_q, xv_n, xd_q, xd_n;
  logic [ADDR_W-1:0] xa_q, xa_n;
  logic [LEN_W-1:0]  xc_q, xc_n;

  logic                        g_load, last_beat, l_load, l_use, exhaust;
  logic [ADDR_W-1:0]           g_load_addr, ent_addr;
  logic [ENT_WORDS*WORD_W-1:0] words;
  logic [WORD_W-1:0]           ent_cnt, ent_flags;
  logic [LEN_W-1:0]            clip;
  logic                        f_last, f_link, f_sink;

  assign ent_addr  = ADDR_W'({words[2*WORD_W-1:WORD_W], words[WORD_W-1:0]});
  assign ent_cnt   = words[3*WORD_W-1:2*WORD_W];
  assign ent_flags = words[4*WORD_W-1:3*WORD_W];
  assign f_last    = ent_flags[FLAG_LAST_BIT];
  assign f_link    = ent_flags[FLAG_LINK_BIT];
  assign f_sink    = ent_flags[FLAG_SINK_BIT];

  sgw_gather #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .ENT_WORDS(ENT_WORDS)) u_gather (
    .clk(clk), .rst_n(rst_n), .load_i(g_load), .load_addr_i(g_load_addr),
    .run_i(state_q == W_FETCH), .beat_valid_i(fetch_valid_i),
    .beat_data_i(fetch_data_i), .fetch_addr_o(fetch_addr_o),
    .last_beat_o(last_beat), .words_o(words)
  );

  sgw_len #(.LEN_W(LEN_W), .CNT_W(WORD_W)) u_len (
    .clk(clk), .rst_n(rst_n), .load_i(l_load), .load_len_i(xfer_len_i),
    .use_i(l_use), .cnt_i(ent_cnt), .clip_o(clip), .exhaust_o(exhaust)
  );

  always_comb begin
    state_n     = state_q;
    wr_n        = wr_q;
    done_n      = 1'b0;
    err_n       = 1'b0;
    code_n      = code_q;
    xv_n        = 1'b0;
    xa_n        = xa_q;
    xc_n        = xc_q;
    xd_n        = xd_q;
    g_load      = 1'b0;
    g_load_addr = tbl_addr_i;
    l_load      = 1'b0;
    l_use       = 1'b0;
    unique case (state_q)
      W_IDLE: if (start_i) begin
        code_n = '0;
        wr_n   = dev_write_i;
        if (|tbl_addr_i[ALIGN_BITS-1:0]) begin
          err_n  = 1'b1;
          code_n = CODE_ALIGN;
        end else if (xfer_len_i == '0) begin
          done_n = 1'b1;
        end else begin
          g_load  = 1'b1;
          l_load  = 1'b1;
          state_n = W_FETCH;
        end
      end
      W_FETCH: if (last_beat) state_n = W_ACT;
      W_ACT: begin
        if (f_link) begin
          if (|ent_addr[ALIGN_BITS-1:0]) begin
            err_n   = 1'b1;
            code_n  = CODE_ALIGN;
            state_n = W_IDLE;
          end else begin
            g_load      = 1'b1;
            g_load_addr = ent_addr;
            state_n     = W_FETCH;
          end
        end else begin
          if (ent_cnt != '0) begin
            xv_n  = 1'b1;
            xa_n  = f_sink ? '0 : ent_addr;
            xc_n  = clip;
            xd_n  = f_sink;
            l_use = 1'b1;
          end
          if (ent_cnt != '0 && exhaust) begin
            done_n  = 1'b1;
            state_n = W_IDLE;
          end else if (f_last) begin
            err_n   = 1'b1;
            code_n  = wr_q ? CODE_SHORT_WR : CODE_SHORT_RD;
            state_n = W_IDLE;
          end else begin
            state_n = W_FETCH;
          end
        end
      end
      default: state_n = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= W_IDLE;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      code_q  <= '0;
      xv_q    <= 1'b0;
      xa_q    <= '0;
      xc_q    <= '0;
      xd_q    <= 1'b0;
    end else begin
      state_q <= state_n;
      wr_q    <= wr_n;
      done_q  <= done_n;
      err_q   <= err_n;
      code_q  <= code_n;
      xv_q    <= xv_n;
      xa_q    <= xa_n;
      xc_q    <= xc_n;
      xd_q    <= xd_n;
    end
  end

  assign fetch_req_o    = (state_q == W_FETCH);
  assign xfer_valid_o   = xv_q;
  assign xfer_addr_o    = xa_q;
  assign xfer_cnt_o     = xc_q;
  assign xfer_discard_o = xd_q;
  assign done_o         = done_q;
  assign err_o          = err_q;
  assign err_code_o     = code_q;

  // R5
  nonzero_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_valid_o |-> xfer_cnt_o != '0);
  // R7
  sink_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid_o && xfer_discard_o) |-> xfer_addr_o == '0);
  // R8
  err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (err_code_o == CODE_SHORT_WR || err_code_o == CODE_SHORT_RD ||
               err_code_o == CODE_ALIGN));
  // R11
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == W_IDLE && !start_i) |=> $stable(err_code_o));
  // R12
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));
endmodule

// File: tb/sim_sg_chain_walker.sv
module sim_sg_chain_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] tbl_addr = '0;
  logic [31:0] xfer_len = '0;
  logic        dev_write = 1'b0;
  logic        fetch_req, fetch_valid;
  logic [63:0] fetch_addr;
  logic [31:0] fetch_data;
  logic        xfer_valid, xfer_discard, done, err;
  logic [63:0] xfer_addr;
  logic [31:0] xfer_cnt;
  logic [5:0]  err_code;

  always #2.5 clk = ~clk;

  sg_chain_walker u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .tbl_addr_i(tbl_addr),
    .xfer_len_i(xfer_len), .dev_write_i(dev_write), .fetch_req_o(fetch_req),
    .fetch_addr_o(fetch_addr), .fetch_valid_i(fetch_valid),
    .fetch_data_i(fetch_data), .xfer_valid_o(xfer_valid),
    .xfer_addr_o(xfer_addr), .xfer_cnt_o(xfer_cnt),
    .xfer_discard_o(xfer_discard), .done_o(done), .err_o(err),
    .err_code_o(err_code)
  );

  logic [31:0] mem [128];
  logic        stall_en = 1'b0;
  logic        stall_t  = 1'b0;

  initial begin
    fetch_valid = 1'b0;
    fetch_data  = '0;
  end

  always @(posedge clk) begin
    #1;
    stall_t     = ~stall_t;
    fetch_valid = fetch_req && (!stall_en || stall_t);
    fetch_data  = mem[fetch_addr[8:2]];
  end

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  int          got_n, got_sum, got_beats, got_out;
  bit          both_seen;
  logic [63:0] first_faddr;
  logic [5:0]  first_code;
  logic [63:0] log_addr [8];
  logic [31:0] log_cnt  [8];
  logic        log_sink [8];

  task automatic run_case(input logic [63:0] tbl, input logic [31:0] len,
                          input logic wr);
    got_n = 0; got_sum = 0; got_beats = 0; got_out = -1; both_seen = 0;
    first_faddr = '1;
    @(negedge clk);
    tbl_addr = tbl; xfer_len = len; dev_write = wr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    first_code = err_code;
    for (int k = 0; k < 400 && got_out < 0; k++) begin
      if (k > 0) @(negedge clk);
      if (fetch_req && fetch_valid) begin
        if (got_beats == 0) first_faddr = fetch_addr;
        got_beats++;
      end
      if (xfer_valid) begin
        if (got_n < 8) begin
          log_addr[got_n] = xfer_addr;
          log_cnt[got_n]  = xfer_cnt;
          log_sink[got_n] = xfer_discard;
        end
        got_n++;
        got_sum += int'(xfer_cnt);
      end
      if (done && err) both_seen = 1;
      if (done)     got_out = 0;
      else if (err) got_out = int'(err_code);
    end
  endtask

  localparam int NC = 10;
  localparam int C_TBL  [NC] = '{'h000, 'h000, 'h000, 'h000, 'h000, 'h040, 'h0C0, 'h0A4, 'h000, 'h100};
  localparam int C_LEN  [NC] = '{'h180, 'h100, 'h200, 'h200, 'h120, 'h050, 'h040, 'h040, 0, 'h010};
  localparam int C_WR   [NC] = '{0, 0, 1, 0, 0, 0, 0, 0, 0, 0};
  localparam int C_N    [NC] = '{2, 1, 2, 2, 2, 2, 0, 0, 0, 0};
  localparam int C_SUM  [NC] = '{'h180, 'h100, 'h180, 'h180, 'h120, 'h050, 0, 0, 0, 0};
  localparam int C_BEAT [NC] = '{8, 4, 8, 8, 8, 16, 4, 0, 0, 4};
  localparam int C_OUT  [NC] = '{0, 0, 7, 8, 0, 0, 16, 16, 0, 8};

  task automatic put_ent(input int widx, input logic [31:0] lo, input logic [31:0] hi,
                         input logic [31:0] cnt, input logic [31:0] flg);
    mem[widx] = lo; mem[widx+1] = hi; mem[widx+2] = cnt; mem[widx+3] = flg;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 32'hBAD0_0000 | 32'(i);
    // chain at 0x000: two data entries, second marked last
    put_ent(0,  32'h0000_1000, 32'h0000_0012, 32'h100, 32'h0);
    put_ent(4,  32'h0000_2000, 32'h0,         32'h080, 32'h8000_0000);
    // chain at 0x040: empty entry, discard entry, link (count and last ignored)
    put_ent(16, 32'h0000_3000, 32'h0,         32'h0,   32'h0);
    put_ent(20, 32'h0000_DEAD, 32'h1,         32'h040, 32'h2000_0000);
    put_ent(24, 32'h0000_0080, 32'h0,         32'h999, 32'hC000_0000);
    // chain at 0x080
    put_ent(32, 32'h0000_4000, 32'h0,         32'h010, 32'h8000_0000);
    // chain at 0x0C0: link to misaligned table
    put_ent(48, 32'h0000_00C4, 32'h0,         32'h0,   32'h4000_0000);
    // chain at 0x100: empty entry marked last
    put_ent(64, 32'h0000_5000, 32'h0,         32'h0,   32'h8000_0000);

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!fetch_req && !xfer_valid && !done && !err, "R1 outputs low in reset",
        {fetch_req, xfer_valid, done, err}, 0);
    chk(err_code == 0, "R1 err_code in reset", err_code, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!fetch_req && !done && !err, "R1 idle after reset", {fetch_req, done, err}, 0);

    for (int i = 0; i < NC; i++) begin
      stall_en = i[0];
      run_case(64'(C_TBL[i]), 32'(C_LEN[i]), C_WR[i][0]);
      chk(got_out == C_OUT[i], $sformatf("R4 R8 R9 R10 case %0d outcome", i), got_out, C_OUT[i]);
      chk(got_n == C_N[i], $sformatf("R3 R5 case %0d transfer count", i), got_n, C_N[i]);
      chk(got_sum == C_SUM[i], $sformatf("R3 case %0d byte total", i), got_sum, C_SUM[i]);
      chk(got_beats == C_BEAT[i], $sformatf("R2 R4 R9 case %0d fetch beats", i), got_beats, C_BEAT[i]);
      chk(!both_seen, $sformatf("R12 case %0d exclusive outcome", i), both_seen, 0);
      if (i == 0) begin
        chk(first_faddr == 64'h0, "R2 first fetch address", first_faddr, 64'h0);
        chk(log_addr[0] == 64'h12_0000_1000, "R2 word order of address", log_addr[0], 64'h12_0000_1000);
        chk(log_cnt[0] == 32'h100, "R3 first count", log_cnt[0], 32'h100);
        chk(log_addr[1] == 64'h2000 && log_cnt[1] == 32'h80, "R3 second entry",
            {log_addr[1][31:0], log_cnt[1]}, {32'h2000, 32'h80});
      end
      if (i == 3) chk(first_code == 0, "R11 start clears code", first_code, 0);
      if (i == 4) chk(log_cnt[1] == 32'h20, "R3 clipped count", log_cnt[1], 32'h20);
      if (i == 5) begin
        chk(log_sink[0] && log_addr[0] == 0, "R7 discard transfer",
            {63'(log_addr[0]), log_sink[0]}, 64'h1);
        chk(log_cnt[0] == 32'h40, "R7 discard count", log_cnt[0], 32'h40);
        chk(!log_sink[1] && log_addr[1] == 64'h4000, "R6 link target followed",
            log_addr[1], 64'h4000);
        chk(log_cnt[1] == 32'h10, "R6 link count ignored", log_cnt[1], 32'h10);
      end
      repeat (3) @(negedge clk);
      chk(err_code == 6'(C_OUT[i]), $sformatf("R11 case %0d code held", i), err_code, C_OUT[i]);
      chk(!done && !err && !xfer_valid, $sformatf("R4 case %0d pulses end", i),
          {done, err, xfer_valid}, 0);
    end

    // R1 reset during a walk
    stall_en = 1'b1;
    @(negedge clk);
    tbl_addr = 64'h040; xfer_len = 32'h50; dev_write = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!fetch_req && !xfer_valid && !done && !err && err_code == 0,
        "R1 reset mid-walk", {fetch_req, xfer_valid, done, err}, 0);
    rst_n = 1'b1;
    stall_en = 1'b0;
    run_case(64'h000, 32'h180, 1'b0);
    chk(got_out == 0 && got_n == 2, "R1 walk after reset", got_n, 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule